// File: doc/BRIEF.md
# Hardware Semaphore Bank with Read-Acquire

The block holds a bank of `N_SEM` one-bit semaphores that several processors use for mutual exclusion. Every bit starts free (0) and reads as 1 while it is held. Software claims a semaphore by reading its word in the acquire window. That single read performs an atomic test-and-set: it returns the old value and leaves the bit set. A returned 0 means the claim succeeded and a returned 1 means another agent already holds the semaphore. Any write to the same word releases the semaphore, whatever the write data.

A second region, the status view, returns all semaphore bits packed into data words and has no side effects. Software uses it to inspect the bank without disturbing it.

The block sits behind a simple register bus that carries one access per cycle and may be shared by several masters through an arbiter. The bus works as follows:
- An access is presented with `bus_en` high for one cycle.
- The semaphore state updates at that clock edge.
- Read data appears on `bus_rdata` in the following cycle, qualified by `bus_rvalid`.

Address bit `ADDR_W-1` selects the region: 0 selects the acquire window and 1 selects the status view.

Top module: `hwsem_bank_top`

## Requirements
- R1: After synchronous reset all semaphores are free: every status word reads 0 and `bus_rvalid` is low until the first read.
- R2: A window read of a free semaphore returns 0 and leaves that semaphore occupied. Occupied means its bit reads 1 in the status view.
- R3: A window read of an occupied semaphore returns 1 and changes no semaphore.
- R4: A write to a window word clears that semaphore to 0 whatever `bus_wdata` holds. A write to an already free semaphore leaves it free.
- R5: Semaphore k is at window byte offset 4*k. Byte address bits [1:0] are ignored, so offsets 4k through 4k+3 all reach semaphore k.
- R6: A read of status word j returns semaphores 32*j through 32*j+31, with semaphore 32*j+b in bit b. The read changes no semaphore.
- R7: Accesses take effect in issue order, one per cycle. Two back-to-back window reads of a free semaphore return 0 and then 1.
- R8: Window reads at offsets 4*N_SEM and above return 0 and change no semaphore. Window writes at those offsets change no semaphore.
- R9: Writes to the status view (address bit 11 set, default parameters) change no semaphore.
- R10: A window read returns the semaphore value in bit 0 with all upper bits 0. `bus_rvalid` is high exactly in the cycle after each read and low after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; top bit selects window (0) or status view (1) |
| bus_wdata | input | DATA_W | Write data (value ignored) |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the read |
| bus_rvalid | output | 1 | High in the cycle after a read |

## Verification
The assertions check on every cycle that the bank state only changes through a window read or a window write. They also check that a window read sets the addressed bit and returns its prior value, that a window write clears the addressed bit, and that read data and `bus_rvalid` follow each access by exactly one cycle with zero upper bits. Only the directed scenarios can show the following:
- the exact address decode, including aliasing of the low address bits, the last valid semaphore and the first out-of-range word;
- the packing of bits into status words;
- the order-dependent outcome of back-to-back acquires.

// File: rtl/hwsem_pkg.sv
package hwsem_pkg;

    localparam int IDX_FIELD_W = 16;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_WIN_RD,
        ACC_WIN_WR,
        ACC_STAT_RD,
        ACC_NULL_RD,
        ACC_NULL_WR
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e               kind;
        logic [IDX_FIELD_W-1:0]  idx;
    } acc_req_t;

    function automatic int words_for(input int bits, input int width);
        return (bits + width - 1) / width;
    endfunction

    function automatic logic is_read(input acc_kind_e k);
        return (k == ACC_WIN_RD) || (k == ACC_STAT_RD) || (k == ACC_NULL_RD);
    endfunction

endpackage

// File: rtl/hwsem_decode.sv
module hwsem_decode
    import hwsem_pkg::*;
#(
    parameter int N_SEM  = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output acc_req_t          req
);
    localparam int N_WORDS = words_for(N_SEM, DATA_W);
    localparam int WIDX_W  = ADDR_W - 3;

    logic [WIDX_W-1:0] word_idx;
    logic              stat_sel;
    logic [1:0]        unused_byte_bits;

    assign word_idx         = addr[ADDR_W-2:2];
    assign stat_sel         = addr[ADDR_W-1];
    assign unused_byte_bits = addr[1:0];

    always_comb begin
        req.idx  = IDX_FIELD_W'(word_idx);
        req.kind = ACC_IDLE;
        if (en) begin
            if (!stat_sel) begin
                if (int'(word_idx) < N_SEM)
                    req.kind = we ? ACC_WIN_WR : ACC_WIN_RD;
                else
                    req.kind = we ? ACC_NULL_WR : ACC_NULL_RD;
            end else begin
                if (we)
                    req.kind = ACC_NULL_WR;
                else if (int'(word_idx) < N_WORDS)
                    req.kind = ACC_STAT_RD;
                else
                    req.kind = ACC_NULL_RD;
            end
        end
    end

endmodule

// File: rtl/hwsem_state.sv
module hwsem_state
    import hwsem_pkg::*;
#(
    parameter int N_SEM = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  acc_req_t         req,
    output logic [N_SEM-1:0] state,
    output logic             old_bit
);
    localparam int SLOT_W = (N_SEM > 1) ? $clog2(N_SEM) : 1;

    logic [N_SEM-1:0]           state_q;
    logic [SLOT_W-1:0]          slot;
    logic [IDX_FIELD_W-1:0]     unused_idx;

    assign slot       = req.idx[SLOT_W-1:0];
    assign unused_idx = req.idx;
    assign old_bit    = state_q[slot];
    assign state      = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            case (req.kind)
                ACC_WIN_RD: state_q[slot] <= 1'b1;
                ACC_WIN_WR: state_q[slot] <= 1'b0;
                default:    state_q       <= state_q;
            endcase
        end
    end

    // R2
    acquire_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (req.kind == ACC_WIN_RD) |=> state_q[$past(slot)]);

    // R4
    release_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (req.kind == ACC_WIN_WR) |=> !state_q[$past(slot)]);

    // R3
    busy_read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req.kind == ACC_WIN_RD && old_bit) |=> $stable(state_q));

    // R6 R8 R9
    no_side_effect_chk: assert property (@(posedge clk) disable iff (rst)
        (req.kind != ACC_WIN_RD && req.kind != ACC_WIN_WR) |=> $stable(state_q));

endmodule

// File: rtl/hwsem_readout.sv
module hwsem_readout
    import hwsem_pkg::*;
#(
    parameter int N_SEM  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_req_t          req,
    input  logic [N_SEM-1:0]  state,
    input  logic              old_bit,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int N_WORDS = words_for(N_SEM, DATA_W);
    localparam int PAD_W   = N_WORDS * DATA_W;

    logic [PAD_W-1:0]  padded;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;
    int                sel;

    assign padded = PAD_W'(state);
    assign sel    = int'(req.idx);

    always_comb begin
        rd_next = '0;
        case (req.kind)
            ACC_WIN_RD:  rd_next = DATA_W'(old_bit);
            ACC_STAT_RD: rd_next = padded[sel*DATA_W +: DATA_W];
            default:     rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= is_read(req.kind);
            if (is_read(req.kind))
                rdata_q <= rd_next;
        end
    end

    assign rdata  = rdata_q;
    assign rvalid = rvalid_q;

    // R10
    rvalid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        is_read(req.kind) |=> rvalid);

    // R10
    rvalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !is_read(req.kind) |=> !rvalid);

    // R10
    win_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req.kind == ACC_WIN_RD) |=> (rdata[DATA_W-1:1] == '0));

    // R2 R3
    win_old_value_chk: assert property (@(posedge clk) disable iff (rst)
        (req.kind == ACC_WIN_RD) |=> (rdata[0] == $past(old_bit)));

    // R8
    null_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req.kind == ACC_NULL_RD) |=> (rdata == '0));

endmodule

// File: rtl/hwsem_bank_top.sv
module hwsem_bank_top
    import hwsem_pkg::*;
#(
    parameter int N_SEM  = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid
);
    acc_req_t          req;
    logic [N_SEM-1:0]  sem_q;
    logic              sem_old;
    logic [DATA_W-1:0] unused_wdata;

    assign unused_wdata = bus_wdata;

    hwsem_decode #(.N_SEM(N_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
        .en   (bus_en),
        .we   (bus_we),
        .addr (bus_addr),
        .req  (req)
    );

    hwsem_state #(.N_SEM(N_SEM)) u_state (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .state   (sem_q),
        .old_bit (sem_old)
    );

    hwsem_readout #(.N_SEM(N_SEM), .DATA_W(DATA_W)) u_readout (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .state   (sem_q),
        .old_bit (sem_old),
        .rdata   (bus_rdata),
        .rvalid  (bus_rvalid)
    );

endmodule

// File: tb/hwsem_bank_top_bench.sv
module hwsem_bank_top_bench;
    localparam int N      = 16;
    localparam int AW     = 12;
    localparam int DW     = 32;
    localparam logic [AW-1:0] STAT = 12'h800;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_en = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          bus_rvalid;

    int checks = 0;
    int failures = 0;
    logic [N-1:0] model = '0;

    always #4 clk = ~clk;

    hwsem_bank_top #(.N_SEM(N), .ADDR_W(AW), .DATA_W(DW)) u_hwsem_bank_top (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    task automatic check_eq(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Caller is at a negedge; sample at the following negedge.
    task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
        check_eq("R10 rvalid after read", {31'd0, bus_rvalid}, 32'd1);
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] v);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        check_eq("R10 rvalid low after write", {31'd0, bus_rvalid}, 32'd0);
    endtask

    task automatic check_status(input string tag);
        logic [DW-1:0] d;
        bus_read(STAT, d);
        check_eq(tag, d, DW'(model));
    endtask

    task automatic t_reset();
        check_eq("R1 rvalid low after reset", {31'd0, bus_rvalid}, 32'd0);
        check_status("R1 status zero after reset");
    endtask

    task automatic t_acquire();
        logic [DW-1:0] d;
        bus_read(12'd12, d);
        check_eq("R2 free read returns 0", d, 32'd0);
        model[3] = 1'b1;
        check_status("R2 bit set after acquire");
        bus_read(12'd12, d);
        check_eq("R3 busy read returns 1", d, 32'd1);
        check_status("R3 state unchanged after busy read");
    endtask

    task automatic t_back_to_back();
        logic [DW-1:0] d0, d1;
        bus_read(12'd28, d0);
        bus_read(12'd28, d1);
        check_eq("R7 first read 0", d0, 32'd0);
        check_eq("R7 second read 1", d1, 32'd1);
        model[7] = 1'b1;
        check_status("R7 state after pair");
    endtask

    task automatic t_release();
        bus_write(12'd12, 32'd0);
        model[3] = 1'b0;
        check_status("R4 release with zero data");
        bus_write(12'd12, 32'hFFFF_FFFF);
        check_status("R4 release of free stays free");
        bus_write(12'd28, 32'h5A5A_0001);
        model[7] = 1'b0;
        check_status("R4 release with arbitrary data");
    endtask

    task automatic t_alias();
        logic [DW-1:0] d;
        bus_read(12'd22, d);
        check_eq("R5 offset 4k+2 acquires", d, 32'd0);
        model[5] = 1'b1;
        check_status("R5 bit5 set");
        bus_read(12'd21, d);
        check_eq("R5 offset 4k+1 sees held", d, 32'd1);
        bus_write(12'd23, 32'd0);
        model[5] = 1'b0;
        check_status("R5 release via 4k+3");
        bus_read(12'd60, d);
        check_eq("R5 last semaphore acquire", d, 32'd0);
        model[15] = 1'b1;
        check_status("R5 bit15 set");
    endtask

    task automatic t_status_view();
        logic [DW-1:0] d;
        bus_read(12'd0, d);
        model[0] = 1'b1;
        check_status("R6 status packing");
        check_status("R6 repeated status read");
        bus_read(12'd0, d);
        check_eq("R6 status read had no side effect", d, 32'd1);
        bus_read(12'd4, d);
        check_eq("R6 neighbour still free", d, 32'd0);
        model[1] = 1'b1;
        bus_read(STAT + 12'd4, d);
        check_eq("R6 status word beyond bank reads 0", d, 32'd0);
        check_status("R6 state after extra word read");
    endtask

    task automatic t_range();
        logic [DW-1:0] d;
        bus_read(12'd64, d);
        check_eq("R8 first out-of-range read 0", d, 32'd0);
        bus_read(12'd64, d);
        check_eq("R8 second out-of-range read 0", d, 32'd0);
        bus_read(12'h7FC, d);
        check_eq("R8 top of window reads 0", d, 32'd0);
        bus_write(12'd64, 32'hFFFF_FFFF);
        check_status("R8 no side effect");
    endtask

    task automatic t_status_write();
        bus_write(STAT, 32'h0000_0000);
        check_status("R9 zero write to status ignored");
        bus_write(STAT, 32'hFFFF_FFFF);
        check_status("R9 ones write to status ignored");
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_acquire();
        t_back_to_back();
        t_release();
        t_alias();
        t_status_view();
        t_range();
        t_status_write();
        @(negedge clk);
        check_eq("R10 rvalid low when idle", {31'd0, bus_rvalid}, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule